// File: doc/BRIEF.md
# Processor Mailbox Channel Unit

This block carries short 32-bit messages between a local processor and a host. The local processor reaches it through a channel port. The host reaches it through a small memory-mapped register port. Three mailboxes sit between the two sides. The outbound mailbox is written locally and read by the host. The outbound interrupt mailbox works the same way, and it also raises an interrupt request toward the host. The inbound mailbox is a four-entry queue that the host writes and the local side reads.

The local side uses valid/ready handshakes. A write or read moves only in a cycle where both valid and ready are high. Ready is low when the addressed mailbox cannot serve the access (full on a write, empty on a read), and this low ready is the local stall. Ready never depends on valid. The local side can also query a channel count at any time. The host side never stalls. Each host read or write takes effect at the clock edge that ends the cycle in which it is strobed, and host read data is valid combinationally during that cycle.

Top module: `mbox_channel_unit`

## Requirements
- R1: After reset, the host status word (address 3) reads 0x00000400. The status word packs its fields as follows: bits [7:0] hold the outbound unread count, bits [15:8] hold the inbound free count, bits [23:16] hold the interrupt-mailbox unread count, and bits [31:24] are zero. The host address map is: 0 reads the outbound mailbox, 1 reads the interrupt mailbox, 2 writes the inbound mailbox, 3 reads the status word.
- R2: The outbound mailbox (channel 0) and the interrupt mailbox (channel 1) each hold one entry. The count that `lc_cnt` returns for each of these channels is its number of free entries: 1 when the mailbox is empty and 0 when it is full.
- R3: While an outbound mailbox is full, a local write to it sees ready low and leaves the stored message unchanged. A host read of that mailbox returns the message and brings the count back to 1. The next local write is then accepted.
- R4: An accepted write to the interrupt mailbox drives `hst_irq` high on the next cycle. `hst_irq` stays high until the host reads address 1 or pulses `hst_irq_clr`. An explicit clear leaves the stored message in place.
- R5: The inbound mailbox (channel 2) returns messages oldest first. Its channel count is the number of unread entries, from 0 to 4.
- R6: A local read of an empty inbound mailbox sees ready low and returns nothing. The read is served once a host write has arrived.
- R7: A host write to a full inbound mailbox does not stall. It overwrites the newest entry, and the count stays at 4.
- R8: Channel 3 is unassigned. So are local writes to channel 2 and local reads of channels 0 and 1. A read of an unassigned channel completes at once and returns 0. A write to an unassigned channel completes at once and changes nothing. A count query on channel 3 returns 0.
- R9: A host read of an empty outbound or interrupt mailbox returns 0xFFFFFFFF and changes no count.
- R10: On the local side, a transfer happens only in a cycle where valid and ready are both high, and ready does not depend on valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_wr_valid | input | 1 | Local channel write request |
| lc_wr_chan | input | 2 | Local write channel number |
| lc_wr_data | input | 32 | Local write data |
| lc_wr_ready | output | 1 | Local write can complete; low means stall |
| lc_rd_valid | input | 1 | Local channel read request |
| lc_rd_chan | input | 2 | Local read channel number |
| lc_rd_ready | output | 1 | Local read can complete; low means stall |
| lc_rd_data | output | 32 | Local read data |
| lc_cnt_chan | input | 2 | Channel selected for a count query |
| lc_cnt | output | 3 | Channel count of the selected channel |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_wr_addr | input | 2 | Host write address |
| hst_wr_data | input | 32 | Host write data |
| hst_rd_en | input | 1 | Host register read strobe |
| hst_rd_addr | input | 2 | Host read address |
| hst_rd_data | output | 32 | Host read data |
| hst_irq_clr | input | 1 | Host explicit clear of the interrupt request |
| hst_irq | output | 1 | Interrupt request toward the host |

## Verification
The assertions assume that the channel and address inputs stay within two bits and that the strobes never go unknown after reset. The queue and slot checks assume that the top gates every push and pop against the current fill. Valid and ready may be high in the same cycle as a host access to the same mailbox. The stimulus changes every input on the falling clock edge and holds it steady through the rising edge. It mixes host and local accesses to one mailbox only in the sequences that the requirements name.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W = 32;
  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    CH_OUT     = 2'd0,
    CH_OUT_IRQ = 2'd1,
    CH_IN      = 2'd2,
    CH_NONE    = 2'd3
  } chan_e;

  typedef enum logic [1:0] {
    HA_OUT     = 2'd0,
    HA_OUT_IRQ = 2'd1,
    HA_IN      = 2'd2,
    HA_STATUS  = 2'd3
  } host_addr_e;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (push) begin
      full <= 1'b1;
      data <= push_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  AST_PUSH_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_POP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !full); // R3
  AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(data))); // R3
endmodule

// File: rtl/mbox_inq.sv
module mbox_inq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = IW + 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IW-1:0]     rd_idx;
  logic [IW-1:0]     tail_idx;
  logic [IW-1:0]     newest_idx;
  logic [IW-1:0]     next_rd;
  logic              is_full;
  logic              overrun;

  function automatic logic [IW-1:0] wrap_idx(input logic [SW-1:0] sum);
    logic [SW-1:0] r;
    r = (sum >= SW'(DEPTH)) ? sum - SW'(DEPTH) : sum;
    return r[IW-1:0];
  endfunction

  assign is_full    = (count == CW'(DEPTH));
  assign overrun    = push && is_full && !pop;
  assign tail_idx   = wrap_idx(SW'(rd_idx) + SW'(count));
  assign newest_idx = wrap_idx(SW'(rd_idx) + SW'(DEPTH - 1));
  assign next_rd    = wrap_idx(SW'(rd_idx) + SW'(1));
  assign head       = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (overrun) begin
        mem[newest_idx] <= push_data;
      end else begin
        if (push) mem[tail_idx] <= push_data;
        if (pop) rd_idx <= next_rd;
        case ({push, pop})
          2'b10:   count <= count + CW'(1);
          2'b01:   count <= count - CW'(1);
          default: count <= count;
        endcase
      end
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R6
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && is_full) |=> is_full); // R7
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq); // R4
endmodule

// File: rtl/mbox_channel_unit.sv
module mbox_channel_unit #(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4,
  parameter int CNT_W    = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lc_wr_valid,
  input  logic [1:0]        lc_wr_chan,
  input  logic [DATA_W-1:0] lc_wr_data,
  output logic              lc_wr_ready,
  input  logic              lc_rd_valid,
  input  logic [1:0]        lc_rd_chan,
  output logic              lc_rd_ready,
  output logic [DATA_W-1:0] lc_rd_data,
  input  logic [1:0]        lc_cnt_chan,
  output logic [CNT_W-1:0]  lc_cnt,
  input  logic              hst_wr_en,
  input  logic [1:0]        hst_wr_addr,
  input  logic [DATA_W-1:0] hst_wr_data,
  input  logic              hst_rd_en,
  input  logic [1:0]        hst_rd_addr,
  output logic [DATA_W-1:0] hst_rd_data,
  input  logic              hst_irq_clr,
  output logic              hst_irq
);
  import mbox_pkg::*;

  localparam int NUM_OUT = 2;

  logic [NUM_OUT-1:0] ob_push;
  logic [NUM_OUT-1:0] ob_pop;
  logic [NUM_OUT-1:0] ob_full;
  logic [DATA_W-1:0]  ob_data [NUM_OUT];
  logic [DATA_W-1:0]  ob_hread [NUM_OUT];

  logic              in_push;
  logic              in_pop;
  logic [DATA_W-1:0] in_head;
  logic [CNT_W-1:0]  in_count;
  logic [CNT_W-1:0]  in_free;
  logic [DATA_W-1:0] status_word;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign ob_push[g]  = lc_wr_valid && (lc_wr_chan == 2'(g)) && !ob_full[g];
    assign ob_pop[g]   = hst_rd_en && (hst_rd_addr == 2'(g)) && ob_full[g];
    assign ob_hread[g] = ob_full[g] ? ob_data[g] : '1;

    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ob_push[g]),
      .push_data (lc_wr_data),
      .pop       (ob_pop[g]),
      .full      (ob_full[g]),
      .data      (ob_data[g])
    );
  end

  assign in_push = hst_wr_en && (hst_wr_addr == HA_IN);
  assign in_pop  = lc_rd_valid && (lc_rd_chan == CH_IN) && (in_count != '0);
  assign in_free = CNT_W'(IN_DEPTH) - in_count;

  mbox_inq #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH)) u_inq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_push),
    .push_data (hst_wr_data),
    .pop       (in_pop),
    .head      (in_head),
    .count     (in_count)
  );

  mbox_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ob_push[CH_OUT_IRQ]),
    .clr   (hst_irq_clr || (hst_rd_en && (hst_rd_addr == HA_OUT_IRQ))),
    .irq   (hst_irq)
  );

  // Local side handshakes
  always_comb begin
    unique case (lc_wr_chan)
      CH_OUT:     lc_wr_ready = !ob_full[CH_OUT];
      CH_OUT_IRQ: lc_wr_ready = !ob_full[CH_OUT_IRQ];
      default:    lc_wr_ready = 1'b1;
    endcase
  end

  always_comb begin
    lc_rd_ready = 1'b1;
    lc_rd_data  = '0;
    if (lc_rd_chan == CH_IN) begin
      lc_rd_ready = (in_count != '0);
      lc_rd_data  = in_head;
    end
  end

  always_comb begin
    unique case (lc_cnt_chan)
      CH_OUT:     lc_cnt = CNT_W'(!ob_full[CH_OUT]);
      CH_OUT_IRQ: lc_cnt = CNT_W'(!ob_full[CH_OUT_IRQ]);
      CH_IN:      lc_cnt = in_count;
      default:    lc_cnt = '0;
    endcase
  end

  // Host side
  assign status_word = DATA_W'({STAT_W'(ob_full[CH_OUT_IRQ]),
                                STAT_W'(in_free),
                                STAT_W'(ob_full[CH_OUT])});

  always_comb begin
    hst_rd_data = '0;
    if (hst_rd_en) begin
      unique case (hst_rd_addr)
        HA_OUT:     hst_rd_data = ob_hread[CH_OUT];
        HA_OUT_IRQ: hst_rd_data = ob_hread[CH_OUT_IRQ];
        HA_STATUS:  hst_rd_data = status_word;
        default:    hst_rd_data = '0;
      endcase
    end
  end

  AST_UNASSIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_rd_valid && (lc_rd_chan != CH_IN)) |-> (lc_rd_ready && lc_rd_data == '0)); // R8
  AST_EMPTY_HOST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd_en && (hst_rd_addr == HA_OUT) && !ob_full[CH_OUT]) |=>
      !ob_full[CH_OUT] || $past(ob_push[CH_OUT])); // R9
  AST_IRQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_wr_valid && lc_wr_ready && (lc_wr_chan == CH_OUT_IRQ)) |=> hst_irq); // R4
  AST_STALL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_wr_valid && !lc_wr_ready && (lc_wr_chan == CH_OUT) && !ob_pop[CH_OUT]) |=>
      $stable(ob_data[CH_OUT])); // R10
endmodule

// File: tb/mbox_channel_unit_test.sv
module mbox_channel_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lc_wr_valid = 1'b0;
  logic [1:0]  lc_wr_chan = '0;
  logic [31:0] lc_wr_data = '0;
  logic        lc_wr_ready;
  logic        lc_rd_valid = 1'b0;
  logic [1:0]  lc_rd_chan = '0;
  logic        lc_rd_ready;
  logic [31:0] lc_rd_data;
  logic [1:0]  lc_cnt_chan = '0;
  logic [2:0]  lc_cnt;
  logic        hst_wr_en = 1'b0;
  logic [1:0]  hst_wr_addr = '0;
  logic [31:0] hst_wr_data = '0;
  logic        hst_rd_en = 1'b0;
  logic [1:0]  hst_rd_addr = '0;
  logic [31:0] hst_rd_data;
  logic        hst_irq_clr = 1'b0;
  logic        hst_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbox_channel_unit uut (
    .clk(clk), .rst_n(rst_n),
    .lc_wr_valid(lc_wr_valid), .lc_wr_chan(lc_wr_chan), .lc_wr_data(lc_wr_data),
    .lc_wr_ready(lc_wr_ready),
    .lc_rd_valid(lc_rd_valid), .lc_rd_chan(lc_rd_chan), .lc_rd_ready(lc_rd_ready),
    .lc_rd_data(lc_rd_data),
    .lc_cnt_chan(lc_cnt_chan), .lc_cnt(lc_cnt),
    .hst_wr_en(hst_wr_en), .hst_wr_addr(hst_wr_addr), .hst_wr_data(hst_wr_data),
    .hst_rd_en(hst_rd_en), .hst_rd_addr(hst_rd_addr), .hst_rd_data(hst_rd_data),
    .hst_irq_clr(hst_irq_clr), .hst_irq(hst_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Advance one clock: inputs were driven after a falling edge, the rising
  // edge applies them, then strobes drop after the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    lc_wr_valid = 1'b0; lc_rd_valid = 1'b0;
    hst_wr_en = 1'b0; hst_rd_en = 1'b0; hst_irq_clr = 1'b0;
  endtask

  task automatic status_exp(input int ob, input int inf, input int irqn,
                            output logic [31:0] s);
    s = (32'(irqn) << 16) | (32'(inf) << 8) | 32'(ob);
  endtask

  task automatic peek_status(output logic [31:0] s);
    hst_rd_en = 1'b1; hst_rd_addr = 2'd3; #1;
    s = hst_rd_data;
    hst_rd_en = 1'b0; #1;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    hst_rd_en = 1'b1; hst_rd_addr = a; #1;
    d = hst_rd_data;
    step();
  endtask

  task automatic host_write(input logic [31:0] d);
    hst_wr_en = 1'b1; hst_wr_addr = 2'd2; hst_wr_data = d;
    step();
  endtask

  task automatic local_write(input logic [1:0] ch, input logic [31:0] d, output logic rdy);
    lc_wr_valid = 1'b1; lc_wr_chan = ch; lc_wr_data = d; #1;
    rdy = lc_wr_ready;
    step();
  endtask

  task automatic local_read(input logic [1:0] ch, output logic rdy, output logic [31:0] d);
    lc_rd_valid = 1'b1; lc_rd_chan = ch; #1;
    rdy = lc_rd_ready; d = lc_rd_data;
    step();
  endtask

  task automatic count_of(input logic [1:0] ch, output logic [2:0] c);
    lc_cnt_chan = ch; #1;
    c = lc_cnt;
  endtask

  initial begin
    logic [31:0] s, e, d;
    logic [2:0]  c;
    logic        r;
    logic [31:0] w [8];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and status layout
    peek_status(s);
    chk("R1 reset status", s, 32'h0000_0400);
    chk("R1 reset irq", 32'(hst_irq), 32'd0);
    count_of(2'd0, c); chk("R2 reset outbound count", 32'(c), 32'd1);
    count_of(2'd1, c); chk("R2 reset irq mailbox count", 32'(c), 32'd1);
    count_of(2'd2, c); chk("R5 reset inbound count", 32'(c), 32'd0);

    // R2 R3 R9 R10 sweep over outbound mailbox
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101);
      host_read(2'd0, d);
      chk("R9 empty outbound read", d, 32'hFFFF_FFFF);
      peek_status(s);
      chk("R9 empty read leaves status", s, 32'h0000_0400);
      local_write(2'd0, v, r);
      chk("R10 write ready when free", 32'(r), 32'd1);
      count_of(2'd0, c); chk("R2 full count", 32'(c), 32'd0);
      peek_status(s); status_exp(1, 4, 0, e); chk("R1 status after write", s, e);
      local_write(2'd0, ~v, r);
      chk("R3 stall when full", 32'(r), 32'd0);
      host_read(2'd0, d);
      chk("R3 host reads kept message", d, v);
      count_of(2'd0, c); chk("R3 count back to one", 32'(c), 32'd1);
    end

    // R4 interrupt mailbox
    local_write(2'd1, 32'h1234_5678, r);
    chk("R4 irq write accepted", 32'(r), 32'd1);
    chk("R4 irq raised", 32'(hst_irq), 32'd1);
    peek_status(s); chk("R1 irq unread field", s, 32'h0001_0400);
    local_write(2'd1, 32'h0, r);
    chk("R3 irq mailbox stalls when full", 32'(r), 32'd0);
    chk("R4 irq held", 32'(hst_irq), 32'd1);
    host_read(2'd1, d);
    chk("R4 irq mailbox data", d, 32'h1234_5678);
    chk("R4 irq cleared by read", 32'(hst_irq), 32'd0);
    host_read(2'd1, d);
    chk("R9 empty irq mailbox read", d, 32'hFFFF_FFFF);
    local_write(2'd1, 32'hCAFE_0001, r);
    chk("R4 irq raised again", 32'(hst_irq), 32'd1);
    hst_irq_clr = 1'b1; step();
    chk("R4 explicit clear", 32'(hst_irq), 32'd0);
    count_of(2'd1, c); chk("R4 clear keeps message", 32'(c), 32'd0);
    host_read(2'd1, d);
    chk("R4 message after clear", d, 32'hCAFE_0001);

    // R5 R6 R7 inbound fill levels 1..6
    for (int n = 1; n <= 6; n++) begin
      int kept;
      local_read(2'd2, r, d);
      chk("R6 empty read stalls", 32'(r), 32'd0);
      for (int k = 0; k < n; k++) begin
        w[k] = 32'h5000_0000 + 32'(n * 16 + k);
        host_write(w[k]);
      end
      kept = (n > 4) ? 4 : n;
      count_of(2'd2, c); chk("R5 R7 inbound count", 32'(c), 32'(kept));
      peek_status(s); status_exp(0, 4 - kept, 0, e); chk("R1 inbound free field", s, e);
      for (int k = 0; k < kept; k++) begin
        logic [31:0] ex;
        ex = (n > 4 && k == 3) ? w[n-1] : w[k];
        local_read(2'd2, r, d);
        chk("R5 R7 inbound order", d, ex);
        chk("R10 read ready when nonempty", 32'(r), 32'd1);
      end
      count_of(2'd2, c); chk("R5 drained", 32'(c), 32'd0);
    end

    // R6 stall released by host write
    local_read(2'd2, r, d);
    chk("R6 stall before write", 32'(r), 32'd0);
    host_write(32'h0BAD_F00D);
    local_read(2'd2, r, d);
    chk("R6 served after write", d, 32'h0BAD_F00D);

    // R8 unassigned channels
    local_write(2'd3, 32'hDEAD_BEEF, r);
    chk("R8 unassigned write completes", 32'(r), 32'd1);
    local_write(2'd2, 32'hDEAD_BEEF, r);
    peek_status(s);
    chk("R8 unassigned writes change nothing", s, 32'h0000_0400);
    count_of(2'd2, c); chk("R8 inbound untouched", 32'(c), 32'd0);
    count_of(2'd3, c); chk("R8 unassigned count", 32'(c), 32'd0);
    local_write(2'd0, 32'h7777_0000, r);
    local_read(2'd0, r, d);
    chk("R8 read of write-only channel", d, 32'd0);
    local_read(2'd3, r, d);
    chk("R8 read of unassigned channel", d, 32'd0);
    chk("R8 unassigned read completes", 32'(r), 32'd1);
    host_read(2'd0, d);
    chk("R8 outbound untouched by local read", d, 32'h7777_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule